// File: doc/BRIEF.md
# Modulus Down-Counter Timebase

This block is a loadable down-counter that advances on prescaled tick pulses. When it runs out, it raises a zero event. The zero event produces a single-cycle latch strobe, and the strobe tells the capture channels and the pulse accumulators to copy their live values into holding registers. Two other sources also produce the strobe: software writing zero as the load value, and a software force command. With the interrupt enabled, each zero event also sets an interrupt flag. Software clears that flag by writing a one.

Two modes are available. In modulus mode the counter starts again from the last written value each time it runs out, which gives a periodic timebase. In one-shot mode it stops at zero and stays there until software writes it again. This block does not include the prescaler or the register decoder. They are expected to supply `tick_en`, the write strobes and the data.

Top module: `mdc_timebase`

## Requirements
- R1: After reset, `count` is 0, `latch_stb` is 0 and `irq_flag` is 0.
- R2: A cycle with `load_wr` high puts `load_val` on `count` after the next clock edge and keeps it as the reload value.
- R3: A cycle with `tick_en` high, `load_wr` low and `count` greater than 1 lowers `count` by exactly one.
- R4: A cycle with `tick_en` high, `load_wr` low and `count` equal to 1 is a zero event, and `latch_stb` is high in the following cycle.
- R5: At a zero event with `mod_en` high, `count` takes the stored reload value.
- R6: At a zero event with `mod_en` low, `count` becomes 0. After that, ticks leave `count` at 0 and raise no strobe.
- R7: A load of value 0 sets `count` to 0 and raises `latch_stb` in the following cycle.
- R8: A cycle with `force_latch` high raises `latch_stb` in the following cycle and leaves `count` unchanged.
- R9: `latch_stb` is high for exactly one cycle for each trigger cycle. This holds even when a zero event and `force_latch` happen in the same cycle.
- R10: A zero event sets `irq_flag` when `irq_en` is high. When `irq_en` is low, `irq_flag` is left as it is.
- R11: A cycle with `irq_clr` high clears `irq_flag`. If a zero event with `irq_en` high happens in the same cycle, the set takes priority and the flag stays 1.
- R12: When `load_wr` and `tick_en` are both high in the same cycle, the load takes priority and no decrement happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count pulse, one cycle per tick |
| load_wr | input | 1 | Write strobe for the modulus value |
| load_val | input | CNT_W | Value written to the counter and the reload register |
| mod_en | input | 1 | 1 selects modulus (reload) mode, 0 selects one-shot mode |
| force_latch | input | 1 | Software command that requests a latch strobe |
| irq_en | input | 1 | Allows zero events to set the interrupt flag |
| irq_clr | input | 1 | Writing a one clears the interrupt flag |
| count | output | CNT_W | Current counter value |
| latch_stb | output | 1 | One-cycle strobe that drives the holding-register transfer |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach is a zero event that lands in the same cycle as another command, such as a force-latch or an interrupt clear. The zero event only happens on the tick taken while `count` equals 1. To get there, the stimulus loads a small value, ticks down until `count` reads 1, and then asserts the tick together with the other command in one cycle. This checks that the strobe stays one cycle wide and that the flag set wins over the clear. To place the one-shot stop exactly, the same approach counts a value of 2 down to zero and then keeps ticking.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
   // Sources that can request a holding-register transfer
   typedef struct packed {
      logic zero_evt;   // counter ran out on a tick
      logic zero_wr;    // software wrote zero
      logic force_req;  // software force command
   } mdc_trig_t;
endpackage

// File: rtl/mdc_counter.sv
module mdc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_val,
   input  logic             mod_en,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt,
   output logic             zero_wr
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("mdc_counter: CNT_W must be in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;

   assign zero_wr  = load_wr && (load_val == ZERO);
   assign zero_evt = !load_wr && tick_en && (cnt_q == ONE);
   assign count    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= ZERO;
         reload_q <= ZERO;
      end else if (load_wr) begin
         cnt_q    <= load_val;
         reload_q <= load_val;
      end else if (tick_en && cnt_q != ZERO) begin
         if (cnt_q == ONE)
            cnt_q <= mod_en ? reload_q : ZERO;
         else
            cnt_q <= cnt_q - ONE;
      end
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (count == $past(load_val)));
   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_wr && count > ONE) |=> (count == $past(count) - ONE));
   assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && !mod_en && count == ZERO) |=> (count == ZERO));
   assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && !tick_en) |=> $stable(count));
endmodule

// File: rtl/mdc_strobe.sv
module mdc_strobe
   import mdc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mdc_trig_t trig,
   output logic      latch_stb
);
   logic any_trig;
   logic stb_q;

   // Several simultaneous sources merge into one pulse
   assign any_trig  = trig.zero_evt | trig.zero_wr | trig.force_req;
   assign latch_stb = stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= any_trig;
   end

   assert_zero_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig.zero_evt |=> latch_stb);
   assert_force_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig.force_req |=> latch_stb);
   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig.zero_evt || trig.zero_wr || trig.force_req) |=> !latch_stb);
endmodule

// File: rtl/mdc_irq.sv
module mdc_irq #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_evt,
   input  logic irq_en,
   input  logic irq_clr,
   output logic irq_flag
);
   logic set_req;
   logic flag_q;
   logic flag_d;

   assign set_req  = zero_evt && irq_en;
   assign irq_flag = flag_q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb begin
            flag_d = flag_q;
            if (irq_clr) flag_d = 1'b0;
            if (set_req) flag_d = 1'b1;
         end
      end else begin : g_clr_wins
         always_comb begin
            flag_d = flag_q;
            if (set_req) flag_d = 1'b1;
            if (irq_clr) flag_d = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && irq_en && (SET_WINS || !irq_clr)) |=> irq_flag);
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(zero_evt && irq_en) && !irq_flag) |=> !irq_flag);
   assert_irq_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !(zero_evt && irq_en)) |=> !irq_flag);
endmodule

// File: rtl/mdc_timebase.sv
module mdc_timebase
   import mdc_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter bit IRQ_SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_val,
   input  logic             mod_en,
   input  logic             force_latch,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count,
   output logic             latch_stb,
   output logic             irq_flag
);
   mdc_trig_t trig;
   logic      zero_evt;
   logic      zero_wr;

   mdc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .load_wr  (load_wr),
      .load_val (load_val),
      .mod_en   (mod_en),
      .count    (count),
      .zero_evt (zero_evt),
      .zero_wr  (zero_wr)
   );

   assign trig.zero_evt  = zero_evt;
   assign trig.zero_wr   = zero_wr;
   assign trig.force_req = force_latch;

   mdc_strobe u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .latch_stb (latch_stb)
   );

   mdc_irq #(.SET_WINS(IRQ_SET_WINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .zero_evt (zero_evt),
      .irq_en   (irq_en),
      .irq_clr  (irq_clr),
      .irq_flag (irq_flag)
   );

   assert_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && load_val == '0) |=> (latch_stb && count == '0));
   assert_load_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && tick_en) |=> (count == $past(load_val)));
endmodule

// File: tb/mdc_timebase_tb.sv
module mdc_timebase_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0, load_wr = 1'b0, mod_en = 1'b0;
   logic         force_latch = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] count;
   logic         latch_stb, irq_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;  // 125 MHz

   mdc_timebase #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_wr(load_wr),
      .load_val(load_val), .mod_en(mod_en), .force_latch(force_latch),
      .irq_en(irq_en), .irq_clr(irq_clr), .count(count),
      .latch_stb(latch_stb), .irq_flag(irq_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock edge; inputs change and outputs are sampled at negedge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet();
      tick_en = 0; load_wr = 0; force_latch = 0; irq_clr = 0;
   endtask

   task automatic do_load(input logic [W-1:0] v);
      load_wr = 1; load_val = v; step(); load_wr = 0;
   endtask

   task automatic t_reset();
      check("R1 count", 32'(count), 0);
      check("R1 latch_stb", 32'(latch_stb), 0);
      check("R1 irq_flag", 32'(irq_flag), 0);
   endtask

   task automatic t_load_and_dec();
      mod_en = 0; irq_en = 0;
      do_load(16'd5);
      check("R2 count after load", 32'(count), 5);
      check("R2 no strobe", 32'(latch_stb), 0);
      tick_en = 1; step();
      check("R3 dec 5->4", 32'(count), 4);
      step();
      check("R3 dec 4->3", 32'(count), 3);
      tick_en = 0; step();
      check("R3 hold without tick", 32'(count), 3);
      tick_en = 1; load_wr = 1; load_val = 16'd9; step(); quiet();
      check("R12 load wins over tick", 32'(count), 9);
   endtask

   task automatic t_modulus();
      mod_en = 1; irq_en = 1;
      do_load(16'd3);
      tick_en = 1; step();
      check("R3 mod dec", 32'(count), 2);
      step();
      check("R3 mod dec", 32'(count), 1);
      check("R4 no strobe before zero", 32'(latch_stb), 0);
      step();
      check("R5 reload", 32'(count), 3);
      check("R4 strobe at zero", 32'(latch_stb), 1);
      check("R10 irq set", 32'(irq_flag), 1);
      tick_en = 0; step();
      check("R9 strobe one cycle", 32'(latch_stb), 0);
      irq_clr = 1; step(); irq_clr = 0;
      check("R11 irq cleared", 32'(irq_flag), 0);
      do_load(16'd1);
      tick_en = 1; irq_clr = 1; step(); quiet();
      check("R11 set beats clear", 32'(irq_flag), 1);
      check("R5 reload of 1", 32'(count), 1);
      irq_clr = 1; step(); irq_clr = 0;
      check("R11 cleared again", 32'(irq_flag), 0);
   endtask

   task automatic t_oneshot();
      mod_en = 0; irq_en = 0;
      do_load(16'd2);
      tick_en = 1; step();
      check("R3 oneshot dec", 32'(count), 1);
      step();
      check("R6 stops at zero", 32'(count), 0);
      check("R4 oneshot strobe", 32'(latch_stb), 1);
      check("R10 no irq when disabled", 32'(irq_flag), 0);
      step(); step();
      check("R6 stays zero", 32'(count), 0);
      check("R6 no further strobe", 32'(latch_stb), 0);
      tick_en = 0;
   endtask

   task automatic t_zero_write();
      do_load(16'd0);
      check("R7 count zero", 32'(count), 0);
      check("R7 strobe", 32'(latch_stb), 1);
      step();
      check("R9 zero-write strobe ends", 32'(latch_stb), 0);
   endtask

   task automatic t_force();
      do_load(16'd7);
      force_latch = 1; step(); force_latch = 0;
      check("R8 strobe", 32'(latch_stb), 1);
      check("R8 count unchanged", 32'(count), 7);
      step();
      check("R9 force strobe ends", 32'(latch_stb), 0);
   endtask

   task automatic t_multi();
      mod_en = 1;
      do_load(16'd2);
      tick_en = 1; step();
      check("R3 multi prep", 32'(count), 1);
      force_latch = 1; step(); quiet();
      check("R9 merged strobe", 32'(latch_stb), 1);
      check("R5 reload in multi", 32'(count), 2);
      step();
      check("R9 merged strobe one cycle", 32'(latch_stb), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_load_and_dec();
      t_modulus();
      t_oneshot();
      t_zero_write();
      t_force();
      t_multi();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule